// File: doc/BRIEF.md
# Output Voltage Power-Good Window Monitor

This block decides whether a regulated output is healthy. It takes a digitised feedback code and a programmable reference code and compares the two against a window. The window has an upper edge and a lower edge. Each edge is a fixed fraction of the reference and has its own trip point and its own release point, so the overvoltage side and the undervoltage side each have separate, asymmetric hysteresis. The thresholds are computed in fixed point as `ref * N / 1000`. To avoid any division, the block compares `fb * 1000` against `ref * N` using integer multiplies.

Feedback samples arrive on a valid/ready stream. The block accepts every sample on the cycle it is offered and never applies back-pressure, so `fb_ready` is held high whenever reset is released. A sample is consumed on every clock edge where `fb_valid` is high.

The two status flags are combined with plain control inputs to form a registered power-good output. These inputs are an enable, a soft-start-complete qualifier and a protection-shutdown flag.

Top module: `pgw_monitor`

## Requirements
- R1: On a clock edge with `fb_valid` high, the overvoltage flag sets when `fb_code*1000 > ref_code*1110`.
- R2: On a valid sample, a set overvoltage flag clears only when `fb_code*1000 <= ref_code*1075`. Samples between the two points leave it unchanged.
- R3: On a clock edge with `fb_valid` high, the undervoltage flag sets when `fb_code*1000 < ref_code*890`.
- R4: On a valid sample, a set undervoltage flag clears only when `fb_code*1000 >= ref_code*925`. Samples between the two points leave it unchanged.
- R5: Both flags hold their value on every edge where `fb_valid` is low, whatever `fb_code` is. `fb_ready` is 1 whenever reset is not active.
- R6: `pgood` is a register. After each edge it equals `enable & ss_done & ~prot_shutdown & ~ov_flag & ~uv_flag`, where the flags are the values updated at that same edge.
- R7: After an edge sampling `enable` low, `pgood` is 0.
- R8: After an edge sampling `prot_shutdown` high, `pgood` is 0.
- R9: While `rst_n` is low, and after it, until an update occurs, `ov_flag`, `uv_flag` and `pgood` are 0.
- R10: After an edge sampling `ss_done` low, `pgood` is 0, even when the window is satisfied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fb_valid | input | 1 | Feedback sample valid |
| fb_ready | output | 1 | Feedback sample ready (no back-pressure) |
| fb_code | input | DW | Feedback sample code |
| ref_code | input | DW | Reference code |
| enable | input | 1 | Regulator enable |
| ss_done | input | 1 | Soft-start completed |
| prot_shutdown | input | 1 | Protection shutdown active |
| pgood | output | 1 | Registered power-good |
| ov_flag | output | 1 | Overvoltage status |
| uv_flag | output | 1 | Undervoltage status |

## Verification
The bench places samples exactly on each trip and release point and one code either side of it. A design with a strict and a non-strict compare swapped would trip or release one code early.

It parks samples inside each hysteresis band. A design without memory there would drop the flag too soon.

It changes `fb_code` wildly while `fb_valid` is low. A design that ignores the strobe would move its flags.

It also toggles `enable`, `ss_done` and `prot_shutdown` while the window is good. A design with a missing gate, or with a cycle of lag on the flags, would show `pgood` high one cycle too long.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  localparam int unsigned SCALE      = 1000;
  localparam int unsigned OV_TRIP_PM = 1110;
  localparam int unsigned OV_REL_PM  = 1075;
  localparam int unsigned UV_TRIP_PM = 890;
  localparam int unsigned UV_REL_PM  = 925;
  localparam int unsigned PM_W       = 11;

  typedef struct packed {
    logic ov_set;
    logic ov_clr;
    logic uv_set;
    logic uv_clr;
  } cmp_t;
endpackage

// File: rtl/pgw_threshold.sv
module pgw_threshold #(
  parameter int unsigned DW         = 12,
  parameter int unsigned OV_TRIP_PM = 1110,
  parameter int unsigned OV_REL_PM  = 1075,
  parameter int unsigned UV_TRIP_PM = 890,
  parameter int unsigned UV_REL_PM  = 925
) (
  input  logic [DW-1:0] fb_i,
  input  logic [DW-1:0] ref_i,
  output pgw_pkg::cmp_t cmp_o
);
  localparam int unsigned PW = DW + pgw_pkg::PM_W;

  logic [PW-1:0] fb_scaled;
  logic [PW-1:0] ov_trip_lvl, ov_rel_lvl, uv_trip_lvl, uv_rel_lvl;

  always_comb begin
    fb_scaled   = PW'(fb_i)  * PW'(pgw_pkg::SCALE);
    ov_trip_lvl = PW'(ref_i) * PW'(OV_TRIP_PM);
    ov_rel_lvl  = PW'(ref_i) * PW'(OV_REL_PM);
    uv_trip_lvl = PW'(ref_i) * PW'(UV_TRIP_PM);
    uv_rel_lvl  = PW'(ref_i) * PW'(UV_REL_PM);
    cmp_o.ov_set = fb_scaled >  ov_trip_lvl;
    cmp_o.ov_clr = fb_scaled <= ov_rel_lvl;
    cmp_o.uv_set = fb_scaled <  uv_trip_lvl;
    cmp_o.uv_clr = fb_scaled >= uv_rel_lvl;
  end
endmodule

// File: rtl/pgw_hyst_flag.sv
module pgw_hyst_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic vld_i,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_d,
  output logic flag_q
);
  always_comb begin
    flag_d = flag_q;
    if (vld_i) begin
      if (set_i)      flag_d = 1'b1;
      else if (clr_i) flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  // R1
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(vld_i && set_i));
  // R2
  flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(vld_i && clr_i));
  // R5
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> $stable(flag_q));
endmodule

// File: rtl/pgw_monitor.sv
module pgw_monitor #(
  parameter int unsigned DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fb_valid,
  output logic          fb_ready,
  input  logic [DW-1:0] fb_code,
  input  logic [DW-1:0] ref_code,
  input  logic          enable,
  input  logic          ss_done,
  input  logic          prot_shutdown,
  output logic          pgood,
  output logic          ov_flag,
  output logic          uv_flag
);
  pgw_pkg::cmp_t cmp;
  logic ov_d, uv_d, pg_d, pg_q;

  pgw_threshold #(
    .DW(DW),
    .OV_TRIP_PM(pgw_pkg::OV_TRIP_PM), .OV_REL_PM(pgw_pkg::OV_REL_PM),
    .UV_TRIP_PM(pgw_pkg::UV_TRIP_PM), .UV_REL_PM(pgw_pkg::UV_REL_PM)
  ) u_thr (
    .fb_i(fb_code), .ref_i(ref_code), .cmp_o(cmp)
  );

  pgw_hyst_flag u_ov (
    .clk(clk), .rst_n(rst_n), .vld_i(fb_valid),
    .set_i(cmp.ov_set), .clr_i(cmp.ov_clr),
    .flag_d(ov_d), .flag_q(ov_flag)
  );

  pgw_hyst_flag u_uv (
    .clk(clk), .rst_n(rst_n), .vld_i(fb_valid),
    .set_i(cmp.uv_set), .clr_i(cmp.uv_clr),
    .flag_d(uv_d), .flag_q(uv_flag)
  );

  assign pg_d = enable & ss_done & ~prot_shutdown & ~ov_d & ~uv_d;

  always_ff @(posedge clk) begin
    if (!rst_n) pg_q <= 1'b0;
    else        pg_q <= pg_d;
  end

  assign pgood    = pg_q;
  assign fb_ready = rst_n;

  // R6
  pg_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pgood |-> (!ov_flag && !uv_flag));
  // R7
  pg_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !pgood);
  // R8
  pg_shutdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prot_shutdown |=> !pgood);
  // R10
  pg_ssdone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_done |=> !pgood);
endmodule

// File: tb/test_pgw_monitor.sv
`timescale 1ns/1ps
module test_pgw_monitor;
  localparam int DW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fb_valid = 1'b0;
  logic fb_ready;
  logic [DW-1:0] fb_code = '0;
  logic [DW-1:0] ref_code = 12'd1000;
  logic enable = 1'b0, ss_done = 1'b0, prot_shutdown = 1'b0;
  logic pgood, ov_flag, uv_flag;

  int checks = 0;
  int failures = 0;
  bit m_ov = 0, m_uv = 0, m_pg = 0;

  always #4 clk = ~clk;

  pgw_monitor #(.DW(DW)) i_pgw_monitor (
    .clk(clk), .rst_n(rst_n), .fb_valid(fb_valid), .fb_ready(fb_ready),
    .fb_code(fb_code), .ref_code(ref_code), .enable(enable),
    .ss_done(ss_done), .prot_shutdown(prot_shutdown),
    .pgood(pgood), .ov_flag(ov_flag), .uv_flag(uv_flag)
  );

  // behavioural reference, integer arithmetic
  always @(posedge clk) begin
    longint f, r;
    f = longint'(fb_code) * 1000;
    r = longint'(ref_code);
    if (!rst_n) begin
      m_ov = 0; m_uv = 0; m_pg = 0;
    end else begin
      if (fb_valid) begin
        if (f > r * 1110) m_ov = 1;
        else if (f <= r * 1075) m_ov = 0;
        if (f < r * 890) m_uv = 1;
        else if (f >= r * 925) m_uv = 0;
      end
      m_pg = enable && ss_done && !prot_shutdown && !m_ov && !m_uv;
    end
  end

  task automatic chk(input string tag, input logic act, input bit exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    #2;
    chk(tag, ov_flag, m_ov, "ov_flag");
    chk(tag, uv_flag, m_uv, "uv_flag");
    chk(tag, pgood, m_pg, "pgood");
    chk(tag, fb_ready, rst_n, "fb_ready");
  endtask

  task automatic samp(input int code, input string tag);
    fb_valid = 1'b1; fb_code = DW'(code);
    step(tag);
  endtask

  initial begin
    #1600000;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    step("R9"); step("R9");
    chk("R9", pgood, 1'b0, "pgood in reset");
    rst_n = 1'b1;
    enable = 1'b1;
    samp(1000, "R10");
    chk("R10", pgood, 1'b0, "pgood before soft-start");
    ss_done = 1'b1;
    samp(1000, "R6");
    chk("R6", pgood, 1'b1, "pgood window ok");
    // overvoltage trip and release
    samp(1110, "R1"); chk("R1", ov_flag, 1'b0, "at trip point");
    samp(1111, "R1"); chk("R1", ov_flag, 1'b1, "above trip");
    chk("R6", pgood, 1'b0, "pgood same edge as ov");
    samp(1076, "R2"); chk("R2", ov_flag, 1'b1, "inside band");
    fb_valid = 1'b0; fb_code = 12'd0; step("R5");
    chk("R5", ov_flag, 1'b1, "no strobe");
    fb_code = 12'd4095; step("R5");
    chk("R5", uv_flag, 1'b0, "no strobe uv");
    samp(1075, "R2"); chk("R2", ov_flag, 1'b0, "at release");
    // undervoltage trip and release
    samp(890, "R3"); chk("R3", uv_flag, 1'b0, "at trip point");
    samp(889, "R3"); chk("R3", uv_flag, 1'b1, "below trip");
    samp(924, "R4"); chk("R4", uv_flag, 1'b1, "inside band");
    samp(925, "R4"); chk("R4", uv_flag, 1'b0, "at release");
    chk("R6", pgood, 1'b1, "pgood back");
    // control gating
    prot_shutdown = 1'b1; samp(1000, "R8");
    chk("R8", pgood, 1'b0, "shutdown");
    prot_shutdown = 1'b0; samp(1000, "R6");
    enable = 1'b0; samp(1000, "R7");
    chk("R7", pgood, 1'b0, "enable low");
    enable = 1'b1; ss_done = 1'b0; samp(1000, "R10");
    chk("R10", pgood, 1'b0, "ss_done low");
    ss_done = 1'b1;
    // different reference
    ref_code = 12'd2000;
    samp(2220, "R1"); chk("R1", ov_flag, 1'b0, "ref2000 at trip");
    samp(2221, "R1"); chk("R1", ov_flag, 1'b1, "ref2000 above trip");
    samp(2150, "R2"); chk("R2", ov_flag, 1'b0, "ref2000 release");
    samp(1779, "R3"); chk("R3", uv_flag, 1'b1, "ref2000 uv trip");
    samp(1850, "R4"); chk("R4", uv_flag, 1'b0, "ref2000 uv release");
    // pseudo-random stream, compared every clock
    begin
      logic [15:0] lfsr = 16'hACE1;
      for (int i = 0; i < 600; i++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        fb_valid = lfsr[0];
        fb_code = DW'(1500 + (int'(lfsr[15:4]) % 1000));
        enable = (lfsr[3:1] != 3'd0);
        ss_done = (lfsr[6:4] != 3'd0);
        prot_shutdown = (lfsr[9:7] == 3'd0);
        step("R6");
      end
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule